// File: doc/BRIEF.md
# Multi-Source Reset Sequencing Controller

This block accepts reset requests from six places and turns each into one of three reset flows of different depth. The six sources are a power-on input, a bidirectional open-drain hard reset pin, a bidirectional open-drain soft reset pin, a watchdog expiry, a bus-monitor expiry and a host-reset command from a test access port. The power-on flow is the deepest. It resets the PLL, every register bank, the peripherals and the cores, drives both pins, and re-captures all configuration. The hard flow does the same work except that the PLL and the power-on-only configuration are left alone, and it reloads the 32-bit hard-reset configuration word. The soft flow drives only the soft pin and resets only the cores.

Each flow holds its pins low for a programmable hold time. The hard pin is released first. The soft pin follows 16 cycles later. The controller then waits until both pins read back high before it returns to idle. A request of higher priority that arrives during a flow restarts the sequence at the higher level. Requests of lower or equal priority that arrive during a flow are dropped. A cause register records the source of each reset as one bit per source, and software clears those bits by writing 1 to them.

Top module: `rst_seq_ctrl`

## Requirements
- R1: A power-on flow starts only after `por_n` has been sampled low on at least 16 consecutive clock edges. A low pulse of 15 cycles starts no flow.
- R2: The power-on flow asserts `pll_rst_o`, `periph_rst_o`, `regbank_rst_o` and `core_rst_o`, and drives both pins. When the hard pin is released it emits one-cycle pulses on both `cfg_pin_sample_o` and `hrcw_load_o`.
- R3: The hard flow drives both pins and asserts core, peripheral and register-bank reset. It pulses `hrcw_load_o` once and never asserts `pll_rst_o` or `cfg_pin_sample_o`.
- R4: The soft flow drives only the soft pin and asserts only `core_rst_o`. It asserts no PLL, peripheral or register-bank reset and emits no strobe.
- R5: Whenever `hard_drv_o` is high, `soft_drv_o` is also high.
- R6: The hard pin is driven for `hold_len_i` cycles, where a value of 0 selects 512. The soft pin is driven for exactly 16 cycles longer. The two configuration strobes fire in the first cycle after the hard pin is released. `core_rst_o` stays high until both pins read back high.
- R7: A low level on the soft pin starts an external soft flow only when the controller is idle. At any other time it has no effect.
- R8: A watchdog or bus-monitor expiry starts a hard flow only while its enable input is 1. With the enable at 0 it has no effect.
- R9: A host-reset command from the test access port, given while idle, starts a soft flow.
- R10: Priority runs power-on > hard > soft. A hard request during a soft flow restarts the sequence as a hard flow, and the hold time counts from the restart. A soft request during a hard flow is dropped.
- R11: Cause bits are: bit 0 power-on, bit 1 external hard, bit 2 external soft, bit 3 watchdog, bit 4 bus monitor, bit 5 test-access-port host reset. Each accepted flow start sets its own bit. A power-on start also clears every other bit.
- R12: Writing 1 to a bit of `cause_clr_i` clears that cause bit and leaves the others unchanged. After `rst_n` every cause bit and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller itself |
| por_n | input | 1 | Power-on reset request, active low |
| hard_pin_i | input | 1 | Read-back of the hard reset pin (low = asserted) |
| soft_pin_i | input | 1 | Read-back of the soft reset pin (low = asserted) |
| wdog_en_i | input | 1 | Watchdog reset enable |
| wdog_expire_i | input | 1 | Watchdog count reached zero |
| bmon_en_i | input | 1 | Bus-monitor reset enable |
| bmon_expire_i | input | 1 | Bus-monitor count reached zero |
| tap_host_rst_i | input | 1 | Host-reset command from the test access port |
| hold_len_i | input | HOLD_W | Pin hold time in cycles, 0 selects HOLD_DEF |
| cause_clr_i | input | 6 | Write-1-to-clear strobes for the cause bits |
| hard_drv_o | output | 1 | Pull-down enable for the hard reset pin |
| soft_drv_o | output | 1 | Pull-down enable for the soft reset pin |
| core_rst_o | output | 1 | Processor core reset |
| periph_rst_o | output | 1 | Peripheral reset |
| regbank_rst_o | output | 1 | Configuration register bank reset |
| pll_rst_o | output | 1 | PLL state reset |
| cfg_pin_sample_o | output | 1 | One-cycle strobe that samples the configuration pins |
| hrcw_load_o | output | 1 | One-cycle strobe that loads the hard-reset configuration word |
| cause_o | output | 6 | Reset-cause status bits |

## Verification
The checker checks these rules on every cycle: hard drive implies soft drive, the PLL reset lies inside a hard-pin drive, peripheral reset lies inside core reset, the strobes fire only while the soft pin is still held after the hard release, and a new power-on bit is always alone. Only the bench scenarios can show the rest. That covers the 15-versus-16-cycle power-on boundary, the exact hold and tail lengths including the 512-cycle default, the dropped and restarted requests, the ignored external soft pin and the disabled watchdog and bus monitor. It also covers the encoding of the cause bits and their write-1-to-clear behaviour.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  // flow depth, encoded so that a larger value wins
  typedef enum logic [1:0] {
    FL_NONE = 2'd0,
    FL_SOFT = 2'd1,
    FL_HARD = 2'd2,
    FL_POR  = 2'd3
  } flow_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_TAIL  = 2'd2,
    ST_WAIT  = 2'd3
  } seq_e;

  localparam int CAUSE_W  = 6;
  localparam int CZ_POR   = 0;
  localparam int CZ_XHARD = 1;
  localparam int CZ_XSOFT = 2;
  localparam int CZ_WDOG  = 3;
  localparam int CZ_BMON  = 4;
  localparam int CZ_TAP   = 5;
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // per-bit two-stage synchronizer, resets to the released (high) level
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/rst_por_filter.sv
module rst_por_filter #(
  parameter int MIN_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_low_i,
  output logic por_act_o
);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!por_low_i)                  cnt_d = '0;
    else if (cnt_q != CW'(MIN_CYC))  cnt_d = cnt_q + 1'b1;
    else                             cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign por_act_o = (cnt_q == CW'(MIN_CYC));
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] set_i,
  input  logic [CAUSE_W-1:0] clr_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q, cause_d;

  always_comb begin
    if (set_i[CZ_POR]) cause_d = CAUSE_W'(1) << CZ_POR;
    else               cause_d = (cause_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int HOLD_W   = 10,
  parameter int HOLD_DEF = 512,
  parameter int TAIL_CYC = 16,
  parameter int POR_MIN  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               por_n,
  input  logic               hard_pin_i,
  input  logic               soft_pin_i,
  input  logic               wdog_en_i,
  input  logic               wdog_expire_i,
  input  logic               bmon_en_i,
  input  logic               bmon_expire_i,
  input  logic               tap_host_rst_i,
  input  logic [HOLD_W-1:0]  hold_len_i,
  input  logic [CAUSE_W-1:0] cause_clr_i,
  output logic               hard_drv_o,
  output logic               soft_drv_o,
  output logic               core_rst_o,
  output logic               periph_rst_o,
  output logic               regbank_rst_o,
  output logic               pll_rst_o,
  output logic               cfg_pin_sample_o,
  output logic               hrcw_load_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam logic [HOLD_W-1:0] HOLD_DEF_V = HOLD_W'(HOLD_DEF);
  localparam logic [HOLD_W-1:0] TAIL_LAST  = HOLD_W'(TAIL_CYC - 1);

  logic [2:0] raw_in, syn_in;
  logic       por_s, hpin_s, spin_s, por_act, por_act_q;

  assign raw_in = {por_n, hard_pin_i, soft_pin_i};
  rst_sync2 #(.W(3)) u_sync (.clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_in));
  assign {por_s, hpin_s, spin_s} = syn_in;

  rst_por_filter #(.MIN_CYC(POR_MIN)) u_porf (
    .clk(clk), .rst_n(rst_n), .por_low_i(~por_s), .por_act_o(por_act));

  seq_e               st_q, st_d;
  flow_e              fl_q, fl_d;
  logic [HOLD_W-1:0]  cnt_q, cnt_d, hold_eff;
  logic               cnt_en, strb_cfg_q, strb_cfg_d, strb_hrcw_q, strb_hrcw_d;
  logic               hard_ok, idle, rq_xh, rq_wd, rq_bm, rq_xs, rq_tp;
  logic [CAUSE_W-1:0] set_v;

  assign hold_eff = (hold_len_i == '0) ? HOLD_DEF_V : hold_len_i;
  assign idle     = (st_q == ST_IDLE);
  // hard-class requests win over idle or a running soft flow only
  assign hard_ok  = idle || (fl_q == FL_SOFT);
  assign rq_xh    = ~hpin_s & hard_ok;
  assign rq_wd    = wdog_expire_i & wdog_en_i & hard_ok;
  assign rq_bm    = bmon_expire_i & bmon_en_i & hard_ok;
  assign rq_xs    = ~spin_s & idle;
  assign rq_tp    = tap_host_rst_i & idle;

  always_comb begin
    set_v = '0;
    if (por_act && !por_act_q) set_v[CZ_POR]   = 1'b1;
    else if (por_act)          set_v           = '0;
    else if (rq_xh)            set_v[CZ_XHARD] = 1'b1;
    else if (rq_wd)            set_v[CZ_WDOG]  = 1'b1;
    else if (rq_bm)            set_v[CZ_BMON]  = 1'b1;
    else if (rq_xs)            set_v[CZ_XSOFT] = 1'b1;
    else if (rq_tp)            set_v[CZ_TAP]   = 1'b1;
  end

  always_comb begin
    st_d        = st_q;
    fl_d        = fl_q;
    cnt_d       = cnt_q;
    cnt_en      = 1'b0;
    strb_cfg_d  = 1'b0;
    strb_hrcw_d = 1'b0;
    if (por_act) begin
      st_d = ST_DRIVE; fl_d = FL_POR; cnt_d = '0; cnt_en = 1'b1;
    end else if (rq_xh || rq_wd || rq_bm) begin
      st_d = ST_DRIVE; fl_d = FL_HARD; cnt_d = '0; cnt_en = 1'b1;
    end else if (rq_xs || rq_tp) begin
      st_d = ST_DRIVE; fl_d = FL_SOFT; cnt_d = '0; cnt_en = 1'b1;
    end else begin
      unique case (st_q)
        ST_DRIVE: begin
          cnt_en = 1'b1;
          if (cnt_q == hold_eff - 1'b1) begin
            st_d        = ST_TAIL;
            cnt_d       = '0;
            strb_cfg_d  = (fl_q == FL_POR);
            strb_hrcw_d = (fl_q != FL_SOFT);
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_TAIL: begin
          cnt_en = 1'b1;
          if (cnt_q == TAIL_LAST) begin
            st_d  = ST_WAIT;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (hpin_s && spin_s) begin
            st_d = ST_IDLE;
            fl_d = FL_NONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      fl_q        <= FL_NONE;
      por_act_q   <= 1'b0;
      strb_cfg_q  <= 1'b0;
      strb_hrcw_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      fl_q        <= fl_d;
      por_act_q   <= por_act;
      strb_cfg_q  <= strb_cfg_d;
      strb_hrcw_q <= strb_hrcw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  rst_cause_reg u_cause (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(cause_clr_i), .cause_o(cause_o));

  assign hard_drv_o       = (st_q == ST_DRIVE) && (fl_q != FL_SOFT);
  assign soft_drv_o       = (st_q == ST_DRIVE) || (st_q == ST_TAIL);
  assign core_rst_o       = !idle;
  assign periph_rst_o     = !idle && (fl_q != FL_SOFT);
  assign regbank_rst_o    = !idle && (fl_q != FL_SOFT);
  assign pll_rst_o        = (st_q == ST_DRIVE) && (fl_q == FL_POR);
  assign cfg_pin_sample_o = strb_cfg_q;
  assign hrcw_load_o      = strb_hrcw_q;
endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hard_drv_o,
  input logic       soft_drv_o,
  input logic       core_rst_o,
  input logic       periph_rst_o,
  input logic       regbank_rst_o,
  input logic       pll_rst_o,
  input logic       cfg_pin_sample_o,
  input logic       hrcw_load_o,
  input logic [5:0] cause_o
);
  // R5
  hard_implies_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_drv_o |-> soft_drv_o);
  // R6
  soft_outlasts_hard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hard_drv_o) |-> soft_drv_o);
  // R2
  pll_within_hard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst_o |-> (hard_drv_o && regbank_rst_o));
  // R4
  periph_within_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_o |-> core_rst_o);
  // R6
  strobe_in_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pin_sample_o || hrcw_load_o) |-> (soft_drv_o && !hard_drv_o && periph_rst_o));
  // R11
  por_cause_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_o[0]) |-> (cause_o[5:1] == 5'b0));
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hard_drv_o(hard_drv_o), .soft_drv_o(soft_drv_o),
  .core_rst_o(core_rst_o), .periph_rst_o(periph_rst_o), .regbank_rst_o(regbank_rst_o),
  .pll_rst_o(pll_rst_o), .cfg_pin_sample_o(cfg_pin_sample_o), .hrcw_load_o(hrcw_load_o),
  .cause_o(cause_o));

// File: tb/rst_seq_ctrl_tb.sv
module rst_seq_ctrl_tb;
  localparam int CLK_PER = 10;
  localparam int HW      = 10;

  logic clk = 1'b0;
  logic rst_n, por_n, wdog_en, wdog_exp, bmon_en, bmon_exp, tap_rst;
  logic ext_hard, ext_soft;
  logic [HW-1:0] hold_len;
  logic [5:0]    cause_clr, cause;
  logic hard_drv, soft_drv, core_rst, periph_rst, regbank_rst, pll_rst, cfg_smp, hrcw_ld;
  logic hard_pin, soft_pin;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PER/2) clk = ~clk;

  // open-drain pins: low when either side pulls
  assign hard_pin = ~(hard_drv | ext_hard);
  assign soft_pin = ~(soft_drv | ext_soft);

  rst_seq_ctrl #(.HOLD_W(HW)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .hard_pin_i(hard_pin), .soft_pin_i(soft_pin),
    .wdog_en_i(wdog_en), .wdog_expire_i(wdog_exp), .bmon_en_i(bmon_en),
    .bmon_expire_i(bmon_exp), .tap_host_rst_i(tap_rst), .hold_len_i(hold_len),
    .cause_clr_i(cause_clr), .hard_drv_o(hard_drv), .soft_drv_o(soft_drv),
    .core_rst_o(core_rst), .periph_rst_o(periph_rst), .regbank_rst_o(regbank_rst),
    .pll_rst_o(pll_rst), .cfg_pin_sample_o(cfg_smp), .hrcw_load_o(hrcw_ld), .cause_o(cause));

  typedef struct packed {
    logic [2:0]  kind;   // 0 ext hard,1 ext soft,2 wdog,3 bmon,4 tap,5 wdog off,6 bmon off
    logic [9:0]  hold;
    logic [9:0]  n_hard;
    logic [9:0]  n_soft;
    logic        periph;
    logic        pll;
    logic        cfg;
    logic        hrcw;
    logic [5:0]  cause;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{3'd0, 10'd20, 10'd20,  10'd36,  1'b1, 1'b0, 1'b0, 1'b1, 6'b000010}, // R3
    '{3'd1, 10'd20, 10'd0,   10'd36,  1'b0, 1'b0, 1'b0, 1'b0, 6'b000100}, // R4 R7
    '{3'd2, 10'd24, 10'd24,  10'd40,  1'b1, 1'b0, 1'b0, 1'b1, 6'b001000}, // R8
    '{3'd3, 10'd24, 10'd24,  10'd40,  1'b1, 1'b0, 1'b0, 1'b1, 6'b010000}, // R8
    '{3'd4, 10'd30, 10'd0,   10'd46,  1'b0, 1'b0, 1'b0, 1'b0, 6'b100000}, // R9
    '{3'd5, 10'd20, 10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 1'b0, 6'b000000}, // R8 off
    '{3'd6, 10'd20, 10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 1'b0, 6'b000000}, // R8 off
    '{3'd0, 10'd0,  10'd512, 10'd528, 1'b1, 1'b0, 1'b0, 1'b1, 6'b000010}  // R6 default
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fire(input int kind);
    @(negedge clk);
    case (kind)
      0: begin ext_hard = 1'b1; repeat (3) @(negedge clk); ext_hard = 1'b0; end
      1: begin ext_soft = 1'b1; repeat (3) @(negedge clk); ext_soft = 1'b0; end
      2: begin wdog_en = 1'b1; wdog_exp = 1'b1; @(negedge clk); wdog_exp = 1'b0; end
      3: begin bmon_en = 1'b1; bmon_exp = 1'b1; @(negedge clk); bmon_exp = 1'b0; end
      4: begin tap_rst = 1'b1; @(negedge clk); tap_rst = 1'b0; end
      5: begin wdog_en = 1'b0; wdog_exp = 1'b1; @(negedge clk); wdog_exp = 1'b0; end
      6: begin bmon_en = 1'b0; bmon_exp = 1'b1; @(negedge clk); bmon_exp = 1'b0; end
      default: ;
    endcase
  endtask

  // counts cycles over one flow; leaves when core reset drops after having risen
  task automatic measure(output int nh, output int ns, output bit pe, output bit rb,
                         output bit pl, output bit cf, output bit hr);
    bit started = 0;
    nh = 0; ns = 0; pe = 0; rb = 0; pl = 0; cf = 0; hr = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (hard_drv)    nh++;
      if (soft_drv)    ns++;
      if (periph_rst)  pe = 1;
      if (regbank_rst) rb = 1;
      if (pll_rst)     pl = 1;
      if (cfg_smp)     cf = 1;
      if (hrcw_ld)     hr = 1;
      if (core_rst) started = 1;
      else if (started) break;
      if (!started && i > 60) break;
    end
  endtask

  task automatic clear_cause(input logic [5:0] m);
    @(negedge clk); cause_clr = m;
    @(negedge clk); cause_clr = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int nh, ns;
    bit pe, rb, pl, cf, hr;
    rst_n = 1'b0; por_n = 1'b1; wdog_en = 1'b0; wdog_exp = 1'b0; bmon_en = 1'b0;
    bmon_exp = 1'b0; tap_rst = 1'b0; ext_hard = 1'b0; ext_soft = 1'b0;
    hold_len = 10'd20; cause_clr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 reset outputs", {hard_drv, soft_drv, core_rst, periph_rst, regbank_rst,
                              pll_rst, cfg_smp, hrcw_ld}, 0);
    chk("R12 reset cause", cause, 0);

    foreach (VEC[k]) begin
      hold_len = VEC[k].hold;
      clear_cause(6'h3f);
      chk("R12 cause cleared", cause, 0);
      fork
        fire(VEC[k].kind);
        measure(nh, ns, pe, rb, pl, cf, hr);
      join
      repeat (3) @(negedge clk);
      chk("R6 hard hold", nh, VEC[k].n_hard);
      chk("R6 soft hold", ns, VEC[k].n_soft);
      chk("R3 R4 periph scope", pe, VEC[k].periph);
      chk("R3 R4 regbank scope", rb, VEC[k].periph);
      chk("R3 R4 pll scope", pl, VEC[k].pll);
      chk("R3 cfg strobe", cf, VEC[k].cfg);
      chk("R3 hrcw strobe", hr, VEC[k].hrcw);
      chk("R11 cause bits", cause, VEC[k].cause);
    end

    // R1: 15-cycle power-on pulse is filtered out
    hold_len = 10'd20;
    @(negedge clk); por_n = 1'b0;
    repeat (15) @(negedge clk); por_n = 1'b1;
    measure(nh, ns, pe, rb, pl, cf, hr);
    chk("R1 short por ignored", ns, 0);

    // R11: cause bits from a soft flow, then power-on clears them
    clear_cause(6'h3f);
    fork fire(4); measure(nh, ns, pe, rb, pl, cf, hr); join
    chk("R9 tap cause", cause, 6'b100000);
    @(negedge clk); por_n = 1'b0;
    fork
      begin repeat (16) @(negedge clk); por_n = 1'b1; end
      measure(nh, ns, pe, rb, pl, cf, hr);
    join
    repeat (3) @(negedge clk);
    chk("R1 16-cycle por starts flow", (nh >= 20), 1);
    chk("R2 pll reset", pl, 1);
    chk("R2 regbank reset", rb, 1);
    chk("R2 cfg strobe", cf, 1);
    chk("R2 hrcw strobe", hr, 1);
    chk("R2 soft tail", ns - nh, 16);
    chk("R11 por clears others", cause, 6'b000001);

    // R10: watchdog during soft flow restarts as hard flow
    clear_cause(6'h3f);
    fork
      fire(4);
      begin @(posedge core_rst); repeat (5) @(negedge clk); fire(2); end
      measure(nh, ns, pe, rb, pl, cf, hr);
    join
    repeat (3) @(negedge clk);
    chk("R10 restart hard hold", nh, 20);
    chk("R10 restart periph", pe, 1);
    chk("R10 restart cause", cause, 6'b101000);

    // R10 R7: tap and external soft during hard flow are dropped
    clear_cause(6'h3f);
    fork
      fire(2);
      begin @(posedge core_rst); repeat (5) @(negedge clk); fire(4); fire(1); end
      measure(nh, ns, pe, rb, pl, cf, hr);
    join
    repeat (3) @(negedge clk);
    chk("R10 dropped soft length", ns, 36);
    chk("R7 ext soft ignored cause", cause, 6'b001000);
    measure(nh, ns, pe, rb, pl, cf, hr);
    chk("R7 no follow-up flow", ns, 0);

    // R12: selective write-1-to-clear
    fork fire(0); measure(nh, ns, pe, rb, pl, cf, hr); join
    chk("R11 accumulate", cause, 6'b001010);
    clear_cause(6'b000010);
    chk("R12 selective clear", cause, 6'b001000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule